// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one parallel data word into a single asynchronous serial character on a TX line. A character is a low start bit, then the data bits with the least-significant bit first, then an optional parity bit, then a high stop period. A baud-clock enable pulse from an outside divisor counter sets the timing. One bit time is sixteen such pulses, and the clock cycles between pulses do not move the line.

The character format is chosen at run time through four line-control inputs: the data length (five to eight bits), parity on or off, even or odd parity, and a stop period of one, one and a half or two bit times. The data word is offered with a valid/ready handshake. The block takes a word only while it is idle, and it captures the data and the format together at that moment. A busy flag is high while a character is on the line.

Top module: `uart_char_tx`

## Requirements
- R1: While reset is asserted and afterwards when nothing is being sent, `txd` is high, `busy` is low and `in_ready` is high.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `busy` is low. `busy` rises on the cycle after acceptance and stays high until the stop period ends. `in_valid` while busy has no effect on the line.
- R3: The start bit drives `txd` low for 16 baud ticks, counted from acceptance.
- R4: The data bits follow the start bit, least-significant bit first, each lasting 16 ticks. The count is 5 + `cfg_len` (codes 0,1,2,3 give 5,6,7,8 bits). Bits above that count are never sent.
- R5: When `cfg_par_en` is 1, one parity bit of 16 ticks follows the last data bit. With `cfg_par_odd` = 0, the ones in the sent data bits plus the parity bit make an even total. With `cfg_par_odd` = 1, that total is odd.
- R6: When `cfg_par_en` is 0, the stop period follows the last data bit directly.
- R7: The stop period holds `txd` high for 16 ticks (`cfg_stop` = 0), 24 ticks (`cfg_stop` = 1) or 32 ticks (`cfg_stop` = 2 or 3).
- R8: The data word and all four format inputs are captured at acceptance. Changes to them while busy do not alter the character in progress.
- R9: If `in_valid` is held high, the next word is accepted on the edge right after the final stop tick. `in_ready` is then high for exactly one cycle, and the new start bit follows with no extra idle time.
- R10: On clock cycles without `baud_tick`, neither `txd` nor `busy` changes while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Baud-clock enable pulse, one cycle wide |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block is idle and will take a word |
| in_data | input | DATA_W | Word to send, LSB first |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | Stop length: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| busy | output | 1 | Character in progress |
| txd | output | 1 | Serial output, idle high |

## Verification
The bench drives random words and formats over every data length, both parity senses and all three stop lengths, under steady, sparse and irregular baud ticks. A design that counted every data bit for parity, or none, would give a wrong parity bit for short lengths with high bits set. A design that treated the 1.5-stop code as one or two bits would let the next start bit arrive 8 ticks early or late. The line-control inputs are scrambled on every cycle while a character is sent, so a design that reads them live instead of capturing them would change the frame mid-flight. The bench also holds `in_valid` high across the end of a character to catch a dead cycle or a missed accept between frames. It also stops the ticks mid-frame to catch a bit timer that runs on the clock instead of on the ticks.

// File: rtl/uart_char_tx_pkg.sv
package uart_char_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_code;
  } tx_fmt_t;

  // number of data bits carried for a given length code
  function automatic int unsigned frame_data_bits(input int unsigned data_w,
                                                  input logic [1:0] len_code);
    return data_w - 32'd3 + {30'd0, len_code};
  endfunction

  // length of the stop period in baud ticks
  function automatic int unsigned stop_period(input int unsigned tpb,
                                              input logic [1:0] stop_code);
    case (stop_code)
      2'b00:   return tpb;
      2'b01:   return tpb + tpb / 2;
      default: return 2 * tpb;
    endcase
  endfunction

  // mask with the lowest nbits set
  function automatic logic [31:0] data_mask(input int unsigned nbits);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if (i < nbits) m[i] = 1'b1;
    return m;
  endfunction

  // parity bit that completes the selected bits to even (odd=0) or odd (odd=1)
  function automatic logic parity_bit(input logic [31:0] data,
                                      input int unsigned nbits,
                                      input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < 32; i++)
      if (i < nbits) acc = acc ^ data[i];
    return acc;
  endfunction

endpackage

// File: rtl/uart_char_tx_timer.sv
module uart_char_tx_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             period_end
);

  logic [CNT_W-1:0] cnt_q;

  assign period_end = run && tick && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= period_end ? '0 : cnt_q + 1'b1;
  end

  // R3: the tick counter never passes the length of the current period
  a_r3_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/uart_char_tx_frame.sv
module uart_char_tx_frame
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] in_data,
  input  tx_fmt_t           fmt_in,
  output tx_fmt_t           fmt_q,
  output logic              data_bit,
  output logic              par_bit
);

  logic [DATA_W-1:0] orig_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic [31:0]       in_ext;

  assign in_ext   = 32'(in_data);
  assign data_bit = sh_q[0];
  assign par_bit  = par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      fmt_q  <= '0;
    end else if (load) begin
      orig_q <= in_data;
      sh_q   <= in_data;
      fmt_q  <= fmt_in;
      par_q  <= parity_bit(in_ext, frame_data_bits(DATA_W, fmt_in.len_code),
                           fmt_in.par_odd);
    end else if (shift) begin
      sh_q   <= sh_q >> 1;
    end
  end

  // R8: the captured format only changes when a new word is taken
  a_r8_format_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(fmt_q));

  // R5: stored parity completes the selected bits of the captured word
  a_r5_parity_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ((^(32'(orig_q) & data_mask(frame_data_bits(DATA_W, fmt_q.len_code)))) ^ par_q)
      == fmt_q.par_odd);

endmodule

// File: rtl/uart_char_tx_seq.sv
module uart_char_tx_seq
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TPB    = 16,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             period_end,
  input  logic [1:0]       len_code,
  input  logic             par_en,
  input  logic [1:0]       stop_code,
  output tx_state_e        state_q,
  output logic [CNT_W-1:0] limit,
  output logic             shift_en
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  tx_state_e        state_d;
  logic [IDX_W-1:0] idx_q;
  logic             last_bit;
  int unsigned      nbits;

  assign nbits    = frame_data_bits(DATA_W, len_code);
  assign last_bit = ({{(32-IDX_W){1'b0}}, idx_q} == nbits - 32'd1);
  assign shift_en = (state_q == ST_DATA) && period_end;
  assign limit    = (state_q == ST_STOP) ? CNT_W'(stop_period(TPB, stop_code))
                                         : CNT_W'(TPB);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)     state_d = ST_START;
      ST_START: if (period_end) state_d = ST_DATA;
      ST_DATA:  if (period_end && last_bit) state_d = par_en ? ST_PAR : ST_STOP;
      ST_PAR:   if (period_end) state_d = ST_STOP;
      ST_STOP:  if (period_end) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept)
        idx_q <= '0;
      else if (shift_en)
        idx_q <= idx_q + 1'b1;
    end
  end

  // R4: the bit index stays inside the selected data length
  a_r4_index_in_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> ({{(32-IDX_W){1'b0}}, idx_q} < nbits));

  // R9: the end of the stop period returns to idle on the next cycle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && period_end) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_char_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  output logic              busy,
  output logic              txd
);

  localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

  tx_state_e        state;
  tx_fmt_t          fmt_in;
  tx_fmt_t          fmt_q;
  logic             accept;
  logic             period_end;
  logic             shift_en;
  logic [CNT_W-1:0] limit;
  logic             data_bit;
  logic             par_bit;

  assign fmt_in   = '{len_code: cfg_len, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, stop_code: cfg_stop};
  assign in_ready = (state == ST_IDLE);
  assign busy     = !in_ready;
  assign accept   = in_valid && in_ready;

  uart_char_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .tick       (baud_tick),
    .limit      (limit),
    .period_end (period_end)
  );

  uart_char_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .shift    (shift_en),
    .in_data  (in_data),
    .fmt_in   (fmt_in),
    .fmt_q    (fmt_q),
    .data_bit (data_bit),
    .par_bit  (par_bit)
  );

  uart_char_tx_seq #(.DATA_W(DATA_W), .TPB(TICKS_PER_BIT), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .period_end (period_end),
    .len_code   (fmt_q.len_code),
    .par_en     (fmt_q.par_en),
    .stop_code  (fmt_q.stop_code),
    .state_q    (state),
    .limit      (limit),
    .shift_en   (shift_en)
  );

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = data_bit;
      ST_PAR:   txd = par_bit;
      default:  txd = 1'b1;
    endcase
  end

  // R2: a completed handshake makes the block busy on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R3: a character always opens with the line low
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R10: cycles without a baud tick leave the line alone
  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> ($stable(txd) && busy));

endmodule

// File: tb/sim_uart_char_tx.sv
module sim_uart_char_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = '0;
  wire        in_ready;
  wire        busy;
  wire        txd;

  uart_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .busy(busy), .txd(txd)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    tick_mode = 0;
  int    phase = 0;
  int    cyc = 0;
  int    last_end = -10;
  bit    done = 1'b0;
  bit    was_idle;
  int    lvl_q[$];
  int    tks_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // baud tick patterns: 0 every cycle, 1 every third, 2 irregular, 3 none
  always @(negedge clk) begin
    phase <= (phase == 2) ? 0 : phase + 1;
    case (tick_mode)
      0:       baud_tick <= 1'b1;
      1:       baud_tick <= (phase == 2);
      2:       baud_tick <= ($urandom % 4) == 0;
      default: baud_tick <= 1'b0;
    endcase
  end

  // reference model: a queue of line levels, each with a tick budget
  task automatic build_frame();
    int nb;
    int ones;
    nb = 5 + int'(cfg_len);
    ones = 0;
    lvl_q.push_back(0); tks_q.push_back(16);
    tag_q.push_back((cyc == last_end + 1) ? "R9 start" : "R3 start");
    for (int i = 0; i < nb; i++) begin
      lvl_q.push_back(int'(in_data[i])); tks_q.push_back(16); tag_q.push_back("R4 data");
      ones += int'(in_data[i]);
    end
    if (cfg_par_en) begin
      lvl_q.push_back((ones % 2) ^ int'(cfg_par_odd)); tks_q.push_back(16);
      tag_q.push_back("R5 parity");
    end
    lvl_q.push_back(1);
    tks_q.push_back(cfg_stop == 2'd0 ? 16 : (cfg_stop == 2'd1 ? 24 : 32));
    tag_q.push_back(cfg_par_en ? "R7 stop" : "R6 stop");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      lvl_q.delete(); tks_q.delete(); tag_q.delete();
    end else begin
      was_idle = (lvl_q.size() == 0);
      if (!was_idle && baud_tick) begin
        tks_q[0] = tks_q[0] - 1;
        if (tks_q[0] == 0) begin
          void'(lvl_q.pop_front()); void'(tks_q.pop_front()); void'(tag_q.pop_front());
          if (lvl_q.size() == 0) last_end = cyc;
        end
      end
      if (was_idle && in_valid) build_frame();
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (lvl_q.size() != 0)
        chk(txd == lvl_q[0][0], tag_q[0], int'(txd), lvl_q[0]);
      else
        chk(txd == 1'b1, "R1 idle line", int'(txd), 1);
      chk(busy == (lvl_q.size() != 0), "R2 busy", int'(busy), int'(lvl_q.size() != 0));
      chk(in_ready == (lvl_q.size() == 0), "R2 ready", int'(in_ready),
          int'(lvl_q.size() == 0));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [7:0] d, input logic [1:0] l, input logic pe,
                      input logic po, input logic [1:0] s);
    bit r;
    in_data = d; cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = s;
    in_valid = 1'b1;
    forever begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int n;
    int idle_cnt;
    bit t0;
    bit b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: 8 bits + parity + 1 stop = 11 bit times of 16 ticks, format scrambled after accept
    tick_mode = 0;
    @(negedge clk);
    send(8'h5A, 2'd3, 1'b1, 1'b0, 2'd0);
    cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_stop = 2'd2; in_data = 8'hFF;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 176, "R8 frame length after format change", n, 176);

    // R7: 1.5 stop, 5 bits, no parity -> (1+5)*16+24 = 120 ticks
    send(8'hE3, 2'd0, 1'b0, 1'b0, 2'd1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 120, "R7 half stop length", n, 120);

    // R9: hold valid across the end of a character
    send(8'h81, 2'd1, 1'b1, 1'b1, 2'd0);
    in_valid = 1'b1; in_data = 8'h3C; cfg_len = 2'd2; cfg_par_en = 1'b0; cfg_stop = 2'd3;
    idle_cnt = 0;
    forever begin
      if (in_ready) begin idle_cnt++; @(negedge clk); break; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(idle_cnt == 1, "R9 ready cycles between frames", idle_cnt, 1);
    chk(busy == 1'b1 && txd == 1'b0, "R9 start follows at once", int'(txd), 0);
    wait_idle();

    // R10: stop the ticks mid-frame
    tick_mode = 1;
    send(8'hA5, 2'd3, 1'b1, 1'b1, 2'd2);
    repeat (100) @(negedge clk);
    tick_mode = 3;
    repeat (2) @(negedge clk);
    t0 = txd; b0 = busy;
    repeat (50) @(negedge clk);
    chk(txd == t0, "R10 line frozen without ticks", int'(txd), int'(t0));
    chk(busy == b0 && b0, "R10 busy held without ticks", int'(busy), 1);
    tick_mode = 1;
    wait_idle();

    // random words and formats; inputs scrambled while busy (R2, R8)
    for (int k = 0; k < 40; k++) begin
      tick_mode = k % 3;
      repeat ($urandom % 3) @(negedge clk);
      send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      while (busy) begin
        in_data = 8'($urandom); cfg_len = 2'($urandom); cfg_par_en = 1'($urandom);
        cfg_par_odd = 1'($urandom); cfg_stop = 2'($urandom); in_valid = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule